// File: doc/BRIEF.md
# Role-Aware Register Operand Resolver

This block is the read side of a 32-name register namespace. Names 0 to 29 are general registers, name 30 is the stack pointer, and name 31 is a pseudo-register with no storage behind it. A read request carries a register name, the role the operand plays in the instruction, and a flag that marks a short-form instruction. The block returns one 64-bit value per request. For the names 0 to 30 this is the stored contents in every role. For name 31 the value depends on the role: zero for an ALU source, the current instruction address for an address base, zero for an address index, and the link register for a member of a load/store-multiple list.

Short-form instructions have a 3-bit register field, so when the short flag is set only the low three bits of the name are used. A plain write port fills the storage, and any write aimed at name 31 is dropped. Requests enter on a valid/ready channel and results leave on a valid/ready channel one cycle later. A result that is not taken is held. While it is held, no new request is accepted.

Top module: `opnd_resolver`

## Requirements
- R1: After reset `rsp_valid` is 0 and every stored register (names 0 to 30) reads as zero.
- R2: For names 0 to 30 the result is the stored value, whatever the role. Roles are encoded 0 = ALU source, 1 = address base, 2 = address index, 3 = register-list member. Name 30 (stack pointer) follows the same rule.
- R3: Name 31 in role 0 (ALU source) returns zero.
- R4: Name 31 in role 1 (address base) returns the `pc` input as sampled at the cycle the request is accepted.
- R5: Name 31 in role 2 (address index) returns zero.
- R6: Name 31 in role 3 (list member) returns the `lr` input as sampled at the cycle the request is accepted.
- R7: When `req_short` is 1, only bits 2:0 of `req_idx` select the register, so name 31 given in short form reads stored register 7 and never the pseudo-register.
- R8: A write with `wr_idx` = 31 has no effect. Later reads of name 31 still give their role-dependent values, and the stored registers keep their contents.
- R9: A request accepted at a clock edge gives `rsp_valid` = 1 with its result after that edge. A read accepted in the same cycle as a write to the same register returns the value from before the write.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_data` stays unchanged and `req_ready` is 0. When `rsp_ready` is 1, a new request can be accepted in the same cycle that the held result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 5 | Register name to write (31 is discarded) |
| wr_data | input | 64 | Write value |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Read request can be accepted |
| req_idx | input | 5 | Register name to read |
| req_role | input | 2 | Operand role: 0 source, 1 base, 2 index, 3 list member |
| req_short | input | 1 | Short-form instruction: use bits 2:0 of the name only |
| pc | input | 64 | Address of the current instruction |
| lr | input | 64 | Link register value |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_data | output | 64 | Resolved operand value |

## Verification
The hardest case to reach is the boundary between the short-form mask and the pseudo-register. A short request naming 31 must land on stored register 7. To show that, the bench loads register 7 with a value that cannot be confused with zero, the `pc` input or the `lr` input, and then issues the short read in the role that would otherwise return the `lr` input. The held-result case is reached by lowering `rsp_ready` before a read and offering a second request behind it. The second request is only released in the cycle the first result is taken.

// File: rtl/opnd_resolver_pkg.sv
package opnd_resolver_pkg;
  typedef enum logic [1:0] {
    ROLE_SRC   = 2'd0,
    ROLE_BASE  = 2'd1,
    ROLE_INDEX = 2'd2,
    ROLE_LIST  = 2'd3
  } opnd_role_e;
endpackage

// File: rtl/opnd_regstore.sv
module opnd_regstore #(
  parameter int XLEN   = 64,
  parameter int NREGS  = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data
);
  localparam int PSEUDO = NREGS - 1;

  logic [XLEN-1:0] rd_vec [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_ent
    if (g == PSEUDO) begin : g_none
      // the last name has no storage; writes to it fall away here
      assign rd_vec[g] = '0;
    end else begin : g_reg
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          q <= '0;
        else if (wr_en && (wr_idx == IDX_W'(g)))
          q <= wr_data;
      end
      assign rd_vec[g] = q;
    end
  end

  assign rd_data = rd_vec[rd_idx];
endmodule

// File: rtl/opnd_select.sv
module opnd_select
  import opnd_resolver_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NREGS  = 32,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic [IDX_W-1:0] idx,
  input  opnd_role_e       role,
  input  logic [XLEN-1:0]  stored,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  lr,
  output logic [XLEN-1:0]  value
);
  localparam logic [IDX_W-1:0] PSEUDO = IDX_W'(NREGS - 1);

  always_comb begin
    value = stored;
    if (idx == PSEUDO) begin
      unique case (role)
        ROLE_SRC:   value = '0;
        ROLE_BASE:  value = pc;
        ROLE_INDEX: value = '0;
        ROLE_LIST:  value = lr;
        default:    value = '0;
      endcase
    end
  end
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opnd_resolver_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int NREGS   = 32,
  parameter int SHORT_W = 3,
  localparam int IDX_W  = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [1:0]       req_role,
  input  logic             req_short,
  input  logic [XLEN-1:0]  pc,
  input  logic [XLEN-1:0]  lr,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [XLEN-1:0]  rsp_data
);
  localparam logic [IDX_W-1:0] PSEUDO = IDX_W'(NREGS - 1);

  logic [IDX_W-1:0] eff_idx;
  logic [XLEN-1:0]  stored_val;
  logic [XLEN-1:0]  resolved;
  opnd_role_e       role_e;
  logic             accept;

  assign eff_idx = req_short ? IDX_W'(req_idx[SHORT_W-1:0]) : req_idx;
  assign role_e  = opnd_role_e'(req_role);

  opnd_regstore #(.XLEN(XLEN), .NREGS(NREGS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (eff_idx),
    .rd_data (stored_val)
  );

  opnd_select #(.XLEN(XLEN), .NREGS(NREGS)) u_sel (
    .idx    (eff_idx),
    .role   (role_e),
    .stored (stored_val),
    .pc     (pc),
    .lr     (lr),
    .value  (resolved)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_data  <= resolved;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: a result that is not taken stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R3: pseudo-register as ALU source
  a_r3_src_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_short && req_idx == PSEUDO && req_role == 2'd0)
      |=> (rsp_valid && rsp_data == '0));

  // R4: pseudo-register as address base
  a_r4_base_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_short && req_idx == PSEUDO && req_role == 2'd1)
      |=> (rsp_valid && rsp_data == $past(pc)));

  // R5: pseudo-register as address index
  a_r5_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_short && req_idx == PSEUDO && req_role == 2'd2)
      |=> (rsp_valid && rsp_data == '0));

  // R6: pseudo-register inside a register list
  a_r6_list_lr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_short && req_idx == PSEUDO && req_role == 2'd3)
      |=> (rsp_valid && rsp_data == $past(lr)));

  // R9: every accepted request produces a result next cycle
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/opnd_resolver_bench.sv
module opnd_resolver_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [4:0]  req_idx = '0;
  logic [1:0]  req_role = '0;
  logic        req_short = 1'b0;
  logic [63:0] pc = '0;
  logic [63:0] lr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [63:0] rsp_data;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  opnd_resolver u_opnd_resolver (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_idx), .req_role(req_role), .req_short(req_short),
    .pc(pc), .lr(lr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [4:0] idx, logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one read with consumer ready; result checked the cycle after acceptance
  task automatic do_read(string tag, logic [4:0] idx, logic [1:0] role, logic sh,
                         logic [63:0] exp);
    @(negedge clk);
    req_valid = 1'b1; req_idx = idx; req_role = role; req_short = sh;
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " valid"}, 64'(rsp_valid), 64'd1);
    chk(tag, rsp_data, exp);
  endtask

  task automatic t_reset;
    chk("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    do_read("R1 r5 reset value", 5'd5, 2'd0, 1'b0, 64'd0);
    do_read("R1 r30 reset value", 5'd30, 2'd1, 1'b0, 64'd0);
  endtask

  task automatic t_stored;
    do_write(5'd0,  64'h1111_0000_0000_0001);
    do_write(5'd12, 64'hC0DE_1200_0000_00AB);
    do_write(5'd30, 64'h0000_7FFF_FFFF_F000);
    do_write(5'd7,  64'h7777_7777_0000_0007);
    do_read("R2 r0 src", 5'd0, 2'd0, 1'b0, 64'h1111_0000_0000_0001);
    do_read("R2 r12 index", 5'd12, 2'd2, 1'b0, 64'hC0DE_1200_0000_00AB);
    for (int r = 0; r < 4; r++)
      do_read($sformatf("R2 r30 role %0d", r), 5'd30, 2'(r), 1'b0, 64'h0000_7FFF_FFFF_F000);
  endtask

  task automatic t_pseudo;
    pc = 64'h0000_0000_4000_1238; lr = 64'h0000_0000_4000_0F00;
    do_read("R3 r31 src zero", 5'd31, 2'd0, 1'b0, 64'd0);
    do_read("R4 r31 base pc", 5'd31, 2'd1, 1'b0, 64'h0000_0000_4000_1238);
    do_read("R5 r31 index zero", 5'd31, 2'd2, 1'b0, 64'd0);
    do_read("R6 r31 list lr", 5'd31, 2'd3, 1'b0, 64'h0000_0000_4000_0F00);
    pc = 64'hFFFF_8000_0000_0010;
    do_read("R4 r31 base new pc", 5'd31, 2'd1, 1'b0, 64'hFFFF_8000_0000_0010);
  endtask

  task automatic t_short;
    do_read("R7 short 31 reads r7", 5'd31, 2'd3, 1'b1, 64'h7777_7777_0000_0007);
    do_read("R7 short 8 reads r0", 5'd8, 2'd0, 1'b1, 64'h1111_0000_0000_0001);
    do_read("R7 short 12 reads r4", 5'd12, 2'd0, 1'b1, 64'd0);
  endtask

  task automatic t_write31;
    do_write(5'd31, 64'hDEAD_BEEF_DEAD_BEEF);
    do_read("R8 r31 src after write", 5'd31, 2'd0, 1'b0, 64'd0);
    do_read("R8 r31 list after write", 5'd31, 2'd3, 1'b0, lr);
    do_read("R8 r30 untouched", 5'd30, 2'd0, 1'b0, 64'h0000_7FFF_FFFF_F000);
    do_read("R8 r0 untouched", 5'd0, 2'd0, 1'b0, 64'h1111_0000_0000_0001);
  endtask

  task automatic t_same_cycle;
    do_write(5'd5, 64'h0000_0000_0000_0055);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 64'h0000_0000_0000_0066;
    req_valid = 1'b1; req_idx = 5'd5; req_role = 2'd0; req_short = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    chk("R9 valid after one cycle", 64'(rsp_valid), 64'd1);
    chk("R9 read during write gives old", rsp_data, 64'h55);
    do_read("R9 later read gives new", 5'd5, 2'd0, 1'b0, 64'h66);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_idx = 5'd12; req_role = 2'd0; req_short = 1'b0;
    @(negedge clk);
    req_idx = 5'd0;   // second request waits
    chk("R10 first result valid", 64'(rsp_valid), 64'd1);
    chk("R10 req_ready low while held", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R10 data held", rsp_data, 64'hC0DE_1200_0000_00AB);
    chk("R10 still valid", 64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second result valid", 64'(rsp_valid), 64'd1);
    chk("R10 second result", rsp_data, 64'h1111_0000_0000_0001);
    @(negedge clk);
    chk("R10 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stored();
    t_pseudo();
    t_short();
    t_write31();
    t_same_cycle();
    t_backpressure();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule